// File: doc/BRIEF.md
# Multi-bank DRAM command scheduler

This block takes read requests, each naming a bank, a row, a column and a caller tag, and turns them into a stream of commands on one shared command/address bus. Every request runs a closed-page sequence: the bank is opened with an activate, read once, and then closed with a precharge. The block keeps timing state for each bank. This lets accesses to different banks interleave on the bus, so their reads overlap in time, while each bank still sees its own minimum spacing between commands.

Up to four requests can be held at once. A request that arrives while all four holding slots are busy is stalled by the ready signal. When more than one command is legal in the same cycle, a fixed order of command types decides first, and the age of the request decides within a type. The block predicts when read data comes back. In that cycle it pulses a data-valid output together with the tag of the request that owns the data.

Top module: `dram_cmd_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, no command is driven (`cmd_valid` low, `cmd_op` 0), `rdata_valid` is low and `req_ready` is high. All banks start closed.
- R2: At most one command appears per cycle. `cmd_op` encodes 0 = none, 1 = activate, 2 = read, 3 = precharge, and `cmd_valid` is high exactly when `cmd_op` is not 0. `cmd_addr` carries the row on an activate, the column on a read and the zero-extended bank number on a precharge.
- R3: A read to a bank appears no earlier than two cycles after the activate to that bank.
- R4: `rdata_valid` pulses exactly one cycle after each read command, and only then. It carries the tag of the request that issued the read.
- R5: A precharge to a bank appears no earlier than two cycles after the read to that bank.
- R6: An activate to a bank appears no earlier than two cycles after the precharge to that bank, so at least one cycle separates the two.
- R7: No more than four requests are held. `req_ready` is low exactly when four are held, and a request is taken when `req_valid` and `req_ready` are both high at a clock edge.
- R8: Each request produces exactly one activate, then one read, then one precharge, all to its own bank. Requests to the same bank are served in the order they were accepted.
- R9: When several commands are legal in one cycle, a read wins over an activate, and an activate wins over a precharge. Within the same command type, the oldest accepted request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | A holding slot is free |
| req_bank | input | 3 | Target bank |
| req_row | input | 14 | Row to open |
| req_col | input | 10 | Column to read |
| req_tag | input | 4 | Caller tag returned with the data |
| cmd_valid | output | 1 | A command is on the bus this cycle |
| cmd_op | output | 2 | Command code (see R2) |
| cmd_bank | output | 3 | Bank the command targets |
| cmd_addr | output | 14 | Row, column or bank number (see R2) |
| rdata_valid | output | 1 | Read data expected on the data bus this cycle |
| rdata_tag | output | 4 | Tag of the request owning that data |

## Verification
Two things can be ready in the same cycle: a read for one bank and an activate (or precharge) for another. Only the read may go, and the other command must slip by exactly one cycle. The bench sets this up by offering requests to different banks on consecutive cycles and by mixing repeated hits to one bank with a random bank stream. A behavioural queue model with per-bank timestamps predicts the command for every cycle. A separate bus monitor then checks spacing and per-bank ordering from the observed commands alone.

// File: rtl/dsch_pkg.sv
// Shared types for the DRAM command scheduler.
// The command codes are visible at the ports; a holding slot also stores
// the next command it waits for, so the same enum acts as its phase.
package dsch_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_ACT = 2'd1,
        OP_RD  = 2'd2,
        OP_PRE = 2'd3
    } dsch_op_e;
endpackage

// File: rtl/dsch_bank_timer.sv
// Per-bank open flag and spacing counters.
// Assumes: at most one of do_act/do_rd/do_pre is high in a cycle, and the
// caller only issues a command when the matching *_ok output is high.
// Each counter is loaded with (gap - 1) on its command and then counts down;
// a gap is met when the counter reads zero. All gaps must be 1 or more.
module dsch_bank_timer #(
    parameter int T_ACT_RD  = 2,
    parameter int T_RD_PRE  = 2,
    parameter int T_PRE_ACT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_rd,
    input  logic do_pre,
    output logic act_ok,
    output logic rd_ok,
    output logic pre_ok
);
    localparam int TMAX1 = (T_ACT_RD > T_RD_PRE) ? T_ACT_RD : T_RD_PRE;
    localparam int TMAX  = (TMAX1 > T_PRE_ACT) ? TMAX1 : T_PRE_ACT;
    localparam int CW    = $clog2(TMAX + 1);
    localparam logic [CW-1:0] LD_AR = CW'(T_ACT_RD - 1);
    localparam logic [CW-1:0] LD_RP = CW'(T_RD_PRE - 1);
    localparam logic [CW-1:0] LD_PA = CW'(T_PRE_ACT - 1);

    logic          open_q;
    logic [CW-1:0] rd_wait, pre_wait, act_wait;

    // Track whether the bank is open and count down each spacing window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q   <= 1'b0;
            rd_wait  <= '0;
            pre_wait <= '0;
            act_wait <= '0;
        end else begin
            if (do_act)      open_q <= 1'b1;
            else if (do_pre) open_q <= 1'b0;
            if (do_act)              rd_wait  <= LD_AR;
            else if (rd_wait != 0)   rd_wait  <= rd_wait - 1'b1;
            if (do_rd)               pre_wait <= LD_RP;
            else if (pre_wait != 0)  pre_wait <= pre_wait - 1'b1;
            if (do_pre)              act_wait <= LD_PA;
            else if (act_wait != 0)  act_wait <= act_wait - 1'b1;
        end
    end

    // A command is legal once its window has closed and the open state fits.
    always_comb begin
        act_ok = !open_q && (act_wait == 0);
        rd_ok  =  open_q && (rd_wait == 0);
        pre_ok =  open_q && (pre_wait == 0);
    end

    assert_rd_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        do_rd |-> (open_q && rd_wait == 0));
    assert_pre_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        do_pre |-> (open_q && pre_wait == 0));
    assert_act_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (!open_q && act_wait == 0));
endmodule

// File: rtl/dsch_age_pick.sv
// Oldest-first picker over N holding slots.
// Keeps an age matrix: older[i][j] set means slot i was accepted before slot j.
// Allocating a slot rewrites its row and column, so entries left over from
// freed slots never matter. Assumes each requesting slot has been allocated.
module dsch_age_pick #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic [IW-1:0] alloc_idx,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt
);
    logic [N-1:0] older [N];

    // Mark a newly allocated slot as younger than every other slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) older[i] <= '0;
        end else if (alloc) begin
            for (int j = 0; j < N; j++) begin
                older[alloc_idx][j] <= 1'b0;
                if (j != int'(alloc_idx)) older[j][alloc_idx] <= 1'b1;
            end
        end
    end

    // Grant a requester only if it is older than every other requester.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            gnt[i] = req[i];
            for (int j = 0; j < N; j++)
                if (j != i && req[j] && !older[i][j]) gnt[i] = 1'b0;
        end
    end

    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    assert_oldest_exists_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> (gnt != '0));
endmodule

// File: rtl/dram_cmd_sched.sv
// DRAM command scheduler, closed-page policy.
// Holds up to MAX_OUT read requests. For each one it issues activate, then
// read, then precharge, interleaving across banks with one command per cycle.
// Commands are registered, so a decision reaches the bus one cycle later.
// Every spacing counts in decision cycles and therefore holds on the bus too.
// Read data is due one bus cycle after the read; rdata_valid marks that cycle.
// Assumes NUM_BANKS and MAX_OUT are powers of two, MAX_OUT >= 2, and that
// the bank number fits in the address width.
module dram_cmd_sched
    import dsch_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int ROW_W     = 14,
    parameter int COL_W     = 10,
    parameter int TAG_W     = 4,
    parameter int MAX_OUT   = 4,
    parameter int T_ACT_RD  = 2,
    parameter int T_RD_PRE  = 2,
    parameter int T_PRE_ACT = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              rdata_valid,
    output logic [TAG_W-1:0]  rdata_tag
);
    localparam int SLOT_W = $clog2(MAX_OUT);

    // Holding slots
    logic [MAX_OUT-1:0] s_valid;
    logic [BANK_W-1:0]  s_bank  [MAX_OUT];
    logic [ROW_W-1:0]   s_row   [MAX_OUT];
    logic [COL_W-1:0]   s_col   [MAX_OUT];
    logic [TAG_W-1:0]   s_tag   [MAX_OUT];
    dsch_op_e           s_phase [MAX_OUT];

    logic [NUM_BANKS-1:0] b_act_ok, b_rd_ok, b_pre_ok;
    logic [NUM_BANKS-1:0] b_do_act, b_do_rd, b_do_pre;
    logic [MAX_OUT-1:0]   act_e, rd_e, pre_e, pick_req, gnt;
    dsch_op_e             cls;
    logic                 issue, alloc;
    logic [SLOT_W-1:0]    sel, free_idx;
    logic [TAG_W-1:0]     cmd_tag_q;

    // One timer per bank.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        dsch_bank_timer #(
            .T_ACT_RD (T_ACT_RD),
            .T_RD_PRE (T_RD_PRE),
            .T_PRE_ACT(T_PRE_ACT)
        ) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .do_act(b_do_act[b]),
            .do_rd (b_do_rd[b]),
            .do_pre(b_do_pre[b]),
            .act_ok(b_act_ok[b]),
            .rd_ok (b_rd_ok[b]),
            .pre_ok(b_pre_ok[b])
        );
    end

    // Work out which slots could legally issue each command type now.
    always_comb begin
        for (int i = 0; i < MAX_OUT; i++) begin
            act_e[i] = s_valid[i] && s_phase[i] == OP_ACT && b_act_ok[s_bank[i]];
            rd_e[i]  = s_valid[i] && s_phase[i] == OP_RD  && b_rd_ok[s_bank[i]];
            pre_e[i] = s_valid[i] && s_phase[i] == OP_PRE && b_pre_ok[s_bank[i]];
        end
    end

    // Pick the command type by fixed priority: read, then activate, then precharge.
    always_comb begin
        if (|rd_e) begin
            pick_req = rd_e;
            cls      = OP_RD;
        end else if (|act_e) begin
            pick_req = act_e;
            cls      = OP_ACT;
        end else begin
            pick_req = pre_e;
            cls      = OP_PRE;
        end
    end

    dsch_age_pick #(.N(MAX_OUT)) u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc    (alloc),
        .alloc_idx(free_idx),
        .req      (pick_req),
        .gnt      (gnt)
    );

    // Turn the grant vector into a slot index, and find the lowest free slot.
    always_comb begin
        issue    = |gnt;
        sel      = '0;
        free_idx = '0;
        for (int i = 0; i < MAX_OUT; i++)
            if (gnt[i]) sel = SLOT_W'(i);
        for (int i = MAX_OUT - 1; i >= 0; i--)
            if (!s_valid[i]) free_idx = SLOT_W'(i);
        req_ready = !(&s_valid);
        alloc     = req_valid && req_ready;
    end

    // Route the issued command to its bank timer.
    always_comb begin
        b_do_act = '0;
        b_do_rd  = '0;
        b_do_pre = '0;
        if (issue) begin
            b_do_act[s_bank[sel]] = (cls == OP_ACT);
            b_do_rd[s_bank[sel]]  = (cls == OP_RD);
            b_do_pre[s_bank[sel]] = (cls == OP_PRE);
        end
    end

    // Accept new requests into free slots and advance the granted slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= '0;
            for (int i = 0; i < MAX_OUT; i++) s_phase[i] <= OP_ACT;
        end else begin
            if (issue) begin
                case (cls)
                    OP_ACT:  s_phase[sel] <= OP_RD;
                    OP_RD:   s_phase[sel] <= OP_PRE;
                    default: s_valid[sel] <= 1'b0;
                endcase
            end
            if (alloc) begin
                s_valid[free_idx] <= 1'b1;
                s_phase[free_idx] <= OP_ACT;
                s_bank[free_idx]  <= req_bank;
                s_row[free_idx]   <= req_row;
                s_col[free_idx]   <= req_col;
                s_tag[free_idx]   <= req_tag;
            end
        end
    end

    // Register the chosen command onto the bus, and flag data one cycle after a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid   <= 1'b0;
            cmd_op      <= OP_NOP;
            cmd_bank    <= '0;
            cmd_addr    <= '0;
            cmd_tag_q   <= '0;
            rdata_valid <= 1'b0;
            rdata_tag   <= '0;
        end else begin
            cmd_valid   <= issue;
            cmd_op      <= issue ? cls : OP_NOP;
            cmd_bank    <= s_bank[sel];
            cmd_tag_q   <= s_tag[sel];
            case (cls)
                OP_ACT:  cmd_addr <= ADDR_W'(s_row[sel]);
                OP_RD:   cmd_addr <= ADDR_W'(s_col[sel]);
                default: cmd_addr <= ADDR_W'(s_bank[sel]);
            endcase
            rdata_valid <= cmd_valid && cmd_op == OP_RD;
            rdata_tag   <= cmd_tag_q;
        end
    end

    assert_data_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_RD) |=> rdata_valid);
    assert_data_only_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_valid |-> $past(cmd_op) == OP_RD);
    assert_full_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(s_valid) == MAX_OUT) |-> !req_ready);
    assert_valid_matches_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid == (cmd_op != OP_NOP));
endmodule

// File: tb/tb_dram_cmd_sched.sv
`timescale 1ns/1ps
module tb_dram_cmd_sched;
    localparam int NB = 8, MAXO = 4;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_ready;
    logic [2:0]  req_bank = 0;
    logic [13:0] req_row = 0;
    logic [9:0]  req_col = 0;
    logic [3:0]  req_tag = 0;
    logic        cmd_valid, rdata_valid;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_addr;
    logic [3:0]  rdata_tag;

    dram_cmd_sched dut (.*);

    always #2 clk = ~clk;   // 250 MHz

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    typedef struct { int bank; int row; int col; int tag; int ph; } ent_t;
    ent_t q[$];
    int   m_open[NB], m_la[NB], m_lr[NB], m_lp[NB];
    int   cyc = 0;
    int   e_valid = 0, e_op = 0, e_bank = 0, e_addr = 0, e_dv = 0, e_tag = 0, e_ready = 1;
    int   pend_tag = 0;
    int   btags[NB][$];
    int   prio[3] = '{2, 1, 3};

    function automatic bit legal(int ph, int b);
        case (ph)
            1: return !m_open[b] && cyc >= m_lp[b] + 2;
            2: return  m_open[b] && cyc >= m_la[b] + 2;
            default: return m_open[b] && cyc >= m_lr[b] + 2;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            for (int b = 0; b < NB; b++) begin
                m_open[b] = 0; m_la[b] = -100; m_lr[b] = -100; m_lp[b] = -100;
                btags[b].delete();
            end
            cyc = 0; e_valid = 0; e_op = 0; e_bank = 0; e_addr = 0;
            e_dv = 0; e_tag = 0; e_ready = 1;
        end else begin
            bit acc;
            int pk;
            acc = req_valid && (q.size() < MAXO);
            e_dv  = (e_op == 2);
            e_tag = e_dv ? pend_tag : e_tag;
            pk = -1;
            for (int p = 0; p < 3 && pk < 0; p++)
                for (int k = 0; k < q.size() && pk < 0; k++)
                    if (q[k].ph == prio[p] && legal(q[k].ph, q[k].bank)) pk = k;
            if (pk < 0) begin
                e_valid = 0; e_op = 0;
            end else begin
                int b;
                b = q[pk].bank;
                e_valid = 1; e_op = q[pk].ph; e_bank = b;
                case (q[pk].ph)
                    1: begin e_addr = q[pk].row; m_open[b] = 1; m_la[b] = cyc; q[pk].ph = 2; end
                    2: begin e_addr = q[pk].col; m_lr[b] = cyc; pend_tag = q[pk].tag; q[pk].ph = 3; end
                    default: begin e_addr = b; m_open[b] = 0; m_lp[b] = cyc; q.delete(pk); end
                endcase
            end
            if (acc) begin
                ent_t e;
                e.bank = int'(req_bank); e.row = int'(req_row); e.col = int'(req_col);
                e.tag = int'(req_tag); e.ph = 1;
                q.push_back(e);
                btags[e.bank].push_back(e.tag);
            end
            e_ready = (q.size() < MAXO);
            cyc++;
        end
    end

    // ---------------- per-cycle comparison and bus monitor ----------------
    int bc = 0, o_st[NB], o_la[NB], o_lr[NB], o_lp[NB], last_rd_bank = -1;
    initial for (int b = 0; b < NB; b++) begin
        o_st[b] = 0; o_la[b] = -100; o_lr[b] = -100; o_lp[b] = -100;
    end

    always @(negedge clk) begin
        if (rst_n) begin
            // R2/R9: model-predicted command each cycle
            chk(cmd_valid == e_valid[0] && cmd_op == 2'(e_op), "R9 cmd_op", cmd_op, e_op);
            if (e_valid != 0) begin
                chk(cmd_bank == 3'(e_bank), "R9 cmd_bank", cmd_bank, e_bank);
                chk(cmd_addr == 14'(e_addr), "R2 cmd_addr", cmd_addr, e_addr);
            end
            chk(rdata_valid == e_dv[0], "R4 rdata_valid", rdata_valid, e_dv);
            chk(req_ready == e_ready[0], "R7 req_ready", req_ready, e_ready);
            // R4/R8: returned tag follows acceptance order within the bank
            if (rdata_valid) begin
                int et;
                et = (last_rd_bank >= 0 && btags[last_rd_bank].size() > 0) ?
                     btags[last_rd_bank].pop_front() : -1;
                chk(int'(rdata_tag) == et, "R8 rdata_tag order", rdata_tag, et);
            end
            last_rd_bank = -1;
            if (cmd_valid) begin
                int b;
                b = int'(cmd_bank);
                case (cmd_op)
                    2'd1: begin
                        chk(o_st[b] == 0, "R8 act order", o_st[b], 0);
                        chk(bc - o_lp[b] >= 2, "R6 pre-act gap", bc - o_lp[b], 2);
                        o_st[b] = 1; o_la[b] = bc;
                    end
                    2'd2: begin
                        chk(o_st[b] == 1, "R8 read order", o_st[b], 1);
                        chk(bc - o_la[b] >= 2, "R3 act-read gap", bc - o_la[b], 2);
                        o_st[b] = 2; o_lr[b] = bc; last_rd_bank = b;
                    end
                    default: begin
                        chk(o_st[b] == 2, "R8 pre order", o_st[b], 2);
                        chk(bc - o_lr[b] >= 2, "R5 read-pre gap", bc - o_lr[b], 2);
                        chk(int'(cmd_addr) == b, "R2 pre addr", cmd_addr, b);
                        o_st[b] = 0; o_lp[b] = bc;
                    end
                endcase
            end
            bc++;
        end
    end

    // ---------------- stimulus ----------------
    int tagc = 0;
    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] nx(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic send(input int b, input int row, input int col);
        bit was;
        req_valid = 1; req_bank = 3'(b); req_row = 14'(row); req_col = 10'(col);
        req_tag = 4'(tagc); tagc++;
        forever begin
            was = req_ready;
            @(negedge clk);
            if (was) break;
        end
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state held
        chk(cmd_valid == 0 && cmd_op == 0, "R1 no cmd in reset", cmd_op, 0);
        chk(rdata_valid == 0, "R1 no data in reset", rdata_valid, 0);
        chk(req_ready == 1, "R1 ready in reset", req_ready, 1);
        rst_n = 1;
        // Overlapped pattern across banks 0,1,2 then bank 0 again
        send(0, 11, 1); send(1, 22, 2); send(2, 33, 3); send(0, 44, 4);
        idle(20);
        // Same bank repeatedly: full close/reopen each time (R6, R8)
        for (int i = 0; i < 4; i++) send(5, 100 + i, 10 + i);
        idle(30);
        // Six distinct banks back to back: fills all slots (R7)
        for (int i = 0; i < 6; i++) send(i + 1, 200 + i, 20 + i);
        idle(30);
        // Pseudo-random stream with gaps and bank repeats (R9 collisions)
        for (int i = 0; i < 300; i++) begin
            lfsr = nx(lfsr);
            send(int'(lfsr[2:0]) & ((lfsr[9]) ? 3 : 7), int'(lfsr[15:3]), int'(lfsr[12:3]));
            if (lfsr[5] && lfsr[6]) idle(int'(lfsr[8:7]) + 1);
        end
        idle(40);
        // R7/R1: drained, ready again and bus quiet
        chk(req_ready == 1, "R7 ready after drain", req_ready, 1);
        chk(cmd_valid == 0, "R2 bus idle after drain", cmd_valid, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule